// File: doc/BRIEF.md
# Counter-Bit Tap Interval Trigger

This block turns a shared free-running counter into periodic events. It watches four tap bits of the counter for each of its control registers and produces an event whenever an enabled tap bit goes from 0 to 1. Because counter bit n rises once every 2^(n+1) counts, each enabled tap sets its own interval. A single register can therefore give several intervals at once.

Each control register is 8 bits wide. Its upper nibble chooses which taps start that register's A/D converter. Its lower nibble chooses which taps raise that register's interrupt. Every register has its own converter-start pulse output and its own sticky interrupt flag. A combined interrupt request is the OR of all the flags. Software loads the registers through a small write port and clears flags by writing zeros through a second write port. The counter and the converters sit outside the block.

Top module: `itv_tap_trigger`

## Requirements
- R1: While `rst_n` is low, every control register is zero and `adc_start_o`, `irq_flag_o` and `irq_o` are all 0.
- R2: When `cfg_we` is 1 at a clock edge, `cfg_wdata` loads the register numbered by `cfg_sel` (0, 1 or 2). The new value first governs the events evaluated at the following edge. A write with `cfg_sel` equal to 3 changes no register.
- R3: Bit k (0..3) of each nibble selects counter bit BASE+k. BASE is 6 for register 0 and 10 for registers 1 and 2. The upper nibble is bits 7..4 and the lower nibble is bits 3..0.
- R4: A tap rises when its counter bit was 0 at the previous clock edge and is 1 at the current edge. If an upper-nibble-enabled tap of register r rises at an edge, `adc_start_o[r]` is 1 for exactly the cycle after that edge. Several taps rising together give one pulse. A bit that stays at 1 gives no further pulse.
- R5: If a lower-nibble-enabled tap of register r rises at an edge, `irq_flag_o[r]` is 1 from the cycle after that edge. It stays set until it is cleared.
- R6: When `flg_we` is 1 at an edge, each flag whose bit in `flg_wdata` is 0 is cleared, and each flag whose bit is 1 is left as it is. A new set event at the same edge wins over the clear.
- R7: `irq_o` is 1 exactly when at least one bit of `irq_flag_o` is 1.
- R8: No tap counts as rising at the first clock edge after reset is released, even if counter bits are already 1.
- R9: Enabling a tap whose counter bit is already 1 produces no pulse and sets no flag.
- R10: Each register drives only its own pulse and flag. Registers with different enables react independently to the same counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cnt_i | input | CNT_W (16) | Free-running counter value |
| cfg_we | input | 1 | Control register write strobe |
| cfg_sel | input | SEL_W (2) | Register number for the write |
| cfg_wdata | input | 8 | Value written to the control register |
| flg_we | input | 1 | Flag clear strobe |
| flg_wdata | input | NUM_REG (3) | Per-flag value; 0 clears that flag, 1 keeps it |
| adc_start_o | output | NUM_REG (3) | One-cycle converter-start pulse per register |
| irq_flag_o | output | NUM_REG (3) | Sticky interrupt flag per register |
| irq_o | output | 1 | OR of all interrupt flags |

## Verification
Each result is due exactly one clock edge after the edge at which the counter shows the rising bit. Pulses and flags are both registered at that edge, and the combined request follows the flags in the same cycle. A configuration write or a flag clear acts at the edge where it is presented, and a new enable governs the edges that come after it. The bench drives one set of inputs per cycle, away from the clock edge. From the previous counter value it predicts what the next edge must produce, waits for that edge, and compares a moment later, so every compare falls in the single cycle where the result is defined. Sweeps cover all sixteen enable nibbles against a counter run long enough to toggle every tap bit, with flag clears interleaved.

// File: rtl/itv_tap_pkg.sv
package itv_tap_pkg;

  // Counter bit index where tap 0 of a given register sits.
  function automatic int unsigned tap_base(input int unsigned reg_idx,
                                           input int unsigned base_first,
                                           input int unsigned base_rest);
    return (reg_idx == 0) ? base_first : base_rest;
  endfunction

  // Any enabled rising tap in a nibble-sized group.
  function automatic logic any_enabled(input logic [3:0] rise,
                                       input logic [3:0] enable);
    return |(rise & enable);
  endfunction

endpackage

// File: rtl/itv_tap_edge.sv
module itv_tap_edge
  import itv_tap_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REG = 3,
  parameter int unsigned TAP_N   = 4,
  parameter int unsigned BASE_A  = 6,
  parameter int unsigned BASE_B  = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [CNT_W-1:0]           cnt_i,
  output logic [NUM_REG*TAP_N-1:0]   rise_o
);

  logic [CNT_W-1:0] prev_q;
  logic             primed_q;
  logic [CNT_W-1:0] rise_all;
  logic             unused_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q   <= '0;
      primed_q <= 1'b0;
    end else begin
      prev_q   <= cnt_i;
      primed_q <= 1'b1;
    end
  end

  // No history exists before the first edge after reset: suppress edges.
  assign rise_all    = primed_q ? (cnt_i & ~prev_q) : '0;
  assign unused_rise = ^rise_all;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    for (genvar t = 0; t < TAP_N; t++) begin : g_tap
      localparam int unsigned BIT = tap_base(r, BASE_A, BASE_B) + t;
      assign rise_o[r*TAP_N + t] = rise_all[BIT];
    end
  end

endmodule

// File: rtl/itv_cfg_regs.sv
module itv_cfg_regs #(
  parameter int unsigned NUM_REG = 3,
  parameter int unsigned CTRL_W  = 8,
  parameter int unsigned SEL_W   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [SEL_W-1:0]            cfg_sel,
  input  logic [CTRL_W-1:0]           cfg_wdata,
  output logic [NUM_REG*CTRL_W-1:0]   ctrl_o
);

  for (genvar r = 0; r < NUM_REG; r++) begin : g_reg
    logic [CTRL_W-1:0] val_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q <= '0;
      end else if (cfg_we && (cfg_sel == SEL_W'(r))) begin
        val_q <= cfg_wdata;
      end
    end
    assign ctrl_o[r*CTRL_W +: CTRL_W] = val_q;
  end

endmodule

// File: rtl/itv_chan.sv
module itv_chan
  import itv_tap_pkg::*;
#(
  parameter int unsigned TAP_N = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*TAP_N-1:0]   ctrl_i,
  input  logic [TAP_N-1:0]     rise_i,
  input  logic                 clr_i,
  output logic                 adc_start_o,
  output logic                 flag_o,
  output logic                 hit_adc_o,
  output logic                 hit_irq_o
);

  logic adc_q;
  logic flag_q;

  if (TAP_N == 4) begin : g_nib
    assign hit_adc_o = any_enabled(rise_i, ctrl_i[2*TAP_N-1:TAP_N]);
    assign hit_irq_o = any_enabled(rise_i, ctrl_i[TAP_N-1:0]);
  end else begin : g_gen
    assign hit_adc_o = |(rise_i & ctrl_i[2*TAP_N-1:TAP_N]);
    assign hit_irq_o = |(rise_i & ctrl_i[TAP_N-1:0]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adc_q  <= 1'b0;
      flag_q <= 1'b0;
    end else begin
      adc_q  <= hit_adc_o;
      // A fresh event outranks a clear in the same cycle.
      flag_q <= hit_irq_o | (flag_q & ~clr_i);
    end
  end

  assign adc_start_o = adc_q;
  assign flag_o      = flag_q;

endmodule

// File: rtl/itv_tap_trigger.sv
module itv_tap_trigger #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned NUM_REG = 3,
  parameter int unsigned TAP_N   = 4,
  parameter int unsigned BASE_A  = 6,
  parameter int unsigned BASE_B  = 10,
  localparam int unsigned CTRL_W = 2 * TAP_N,
  localparam int unsigned SEL_W  = (NUM_REG > 1) ? $clog2(NUM_REG + 1) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [CNT_W-1:0]     cnt_i,
  input  logic                 cfg_we,
  input  logic [SEL_W-1:0]     cfg_sel,
  input  logic [CTRL_W-1:0]    cfg_wdata,
  input  logic                 flg_we,
  input  logic [NUM_REG-1:0]   flg_wdata,
  output logic [NUM_REG-1:0]   adc_start_o,
  output logic [NUM_REG-1:0]   irq_flag_o,
  output logic                 irq_o
);

  logic [NUM_REG*TAP_N-1:0]  rise_w;
  logic [NUM_REG*CTRL_W-1:0] ctrl_w;
  logic [NUM_REG-1:0]        clr_w;
  logic [NUM_REG-1:0]        hit_adc_w;
  logic [NUM_REG-1:0]        hit_irq_w;

  itv_tap_edge #(
    .CNT_W(CNT_W), .NUM_REG(NUM_REG), .TAP_N(TAP_N),
    .BASE_A(BASE_A), .BASE_B(BASE_B)
  ) u_edge (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .rise_o(rise_w)
  );

  itv_cfg_regs #(
    .NUM_REG(NUM_REG), .CTRL_W(CTRL_W), .SEL_W(SEL_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ctrl_o(ctrl_w)
  );

  assign clr_w = {NUM_REG{flg_we}} & ~flg_wdata;

  for (genvar r = 0; r < NUM_REG; r++) begin : g_chan
    itv_chan #(.TAP_N(TAP_N)) u_chan (
      .clk(clk),
      .rst_n(rst_n),
      .ctrl_i(ctrl_w[r*CTRL_W +: CTRL_W]),
      .rise_i(rise_w[r*TAP_N +: TAP_N]),
      .clr_i(clr_w[r]),
      .adc_start_o(adc_start_o[r]),
      .flag_o(irq_flag_o[r]),
      .hit_adc_o(hit_adc_w[r]),
      .hit_irq_o(hit_irq_w[r])
    );
  end

  assign irq_o = |irq_flag_o;

endmodule

// File: rtl/itv_tap_trigger_chk.sv
module itv_tap_trigger_chk #(
  parameter int unsigned NUM_REG = 3,
  parameter int unsigned TAP_N   = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       flg_we,
  input logic [NUM_REG-1:0]         flg_wdata,
  input logic [NUM_REG*TAP_N-1:0]   rise_w,
  input logic [NUM_REG-1:0]         hit_adc_w,
  input logic [NUM_REG-1:0]         hit_irq_w,
  input logic [NUM_REG-1:0]         adc_start_o,
  input logic [NUM_REG-1:0]         irq_flag_o,
  input logic                       irq_o
);

  // R8: first edge after reset release sees no rising tap.
  a_r8_no_edge_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(rst_n)) |-> (rise_w == '0));

  // R7: combined request agrees with the flags.
  a_r7_irq_or: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == ($countones(irq_flag_o) != 0));

  for (genvar r = 0; r < NUM_REG; r++) begin : g_r
    // R4: a pulse needs an enabled rising tap one edge earlier.
    a_r4_pulse_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
      adc_start_o[r] |-> $past(hit_adc_w[r]));
    // R4: no enabled rise means no pulse next cycle.
    a_r4_no_cause_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !hit_adc_w[r] |=> !adc_start_o[r]);
    // R5: enabled interrupt tap sets the flag.
    a_r5_flag_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit_irq_w[r] |=> irq_flag_o[r]);
    // R5: flag stays set unless cleared.
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_flag_o[r] && !(flg_we && !flg_wdata[r])) |=> irq_flag_o[r]);
    // R6: clear without a new event empties the flag.
    a_r6_flag_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (flg_we && !flg_wdata[r] && !hit_irq_w[r]) |=> !irq_flag_o[r]);
  end

endmodule

bind itv_tap_trigger itv_tap_trigger_chk #(
  .NUM_REG(NUM_REG), .TAP_N(TAP_N)
) u_chk (
  .clk(clk), .rst_n(rst_n), .flg_we(flg_we), .flg_wdata(flg_wdata),
  .rise_w(rise_w), .hit_adc_w(hit_adc_w), .hit_irq_w(hit_irq_w),
  .adc_start_o(adc_start_o), .irq_flag_o(irq_flag_o), .irq_o(irq_o)
);

// File: tb/itv_tap_trigger_bench.sv
module itv_tap_trigger_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt_i = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        flg_we = 1'b0;
  logic [2:0]  flg_wdata = '1;
  logic [2:0]  adc_start_o;
  logic [2:0]  irq_flag_o;
  logic        irq_o;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  logic [7:0]  m_ctrl [3];
  logic [15:0] m_prev;
  bit          m_primed;
  logic [2:0]  m_flag;
  logic [15:0] cur_c;

  always #(CLK_PERIOD/2) clk = ~clk;

  itv_tap_trigger u_itv_tap_trigger (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .cfg_we(cfg_we),
    .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .flg_we(flg_we),
    .flg_wdata(flg_wdata), .adc_start_o(adc_start_o),
    .irq_flag_o(irq_flag_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what,
                     input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // One clock: drive, predict, wait for the edge, compare just after it.
  task automatic step(input logic [15:0] c, input logic we, input logic [1:0] sel,
                      input logic [7:0] d, input logic fwe, input logic [2:0] fd,
                      input string req);
    logic [2:0] e_adc;
    logic [2:0] e_flag;
    for (int r = 0; r < 3; r++) begin
      int base;
      logic [3:0] up;
      base = (r == 0) ? 6 : 10;
      up = m_primed ? 4'((c >> base) & ~(m_prev >> base)) : 4'b0;
      e_adc[r]  = |(up & m_ctrl[r][7:4]);
      e_flag[r] = (|(up & m_ctrl[r][3:0])) | (m_flag[r] & ~(fwe & ~fd[r]));
    end
    cnt_i = c; cfg_we = we; cfg_sel = sel; cfg_wdata = d;
    flg_we = fwe; flg_wdata = fd;
    if (we && sel < 2'd3) m_ctrl[sel] = d;
    m_prev = c; m_primed = 1'b1; m_flag = e_flag; cur_c = c;
    @(posedge clk);
    #1;
    chk(req, "adc_start", adc_start_o, e_adc);
    chk(req, "irq_flag", irq_flag_o, e_flag);
    chk("R7", "irq", {2'b00, irq_o}, {2'b00, |e_flag});
    cfg_we = 1'b0; flg_we = 1'b0;
  endtask

  task automatic cfg(input logic [1:0] sel, input logic [7:0] d);
    step(cur_c, 1'b1, sel, d, 1'b0, 3'b111, "R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    for (int r = 0; r < 3; r++) m_ctrl[r] = '0;
    m_flag = '0; m_prev = '0; m_primed = 1'b0;
    cur_c = 16'hFFFF; cnt_i = 16'hFFFF;
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "adc_start in reset", adc_start_o, 3'b000);
    chk("R1", "irq_flag in reset", irq_flag_o, 3'b000);
    chk("R1", "irq in reset", {2'b00, irq_o}, 3'b000);
    rst_n = 1'b1;

    // R8: counter already all ones at first edge; R1: regs cleared by reset
    step(16'hFFFF, 0, 0, 0, 0, 3'b111, "R8");
    // R9: enable all taps while bits high -> nothing
    cfg(2'd0, 8'hFF); cfg(2'd1, 8'hFF); cfg(2'd2, 8'hFF);
    step(16'hFFFF, 0, 0, 0, 0, 3'b111, "R9");
    step(16'h0000, 0, 0, 0, 0, 3'b111, "R4");
    // R4: many taps rise together -> single one-cycle pulse
    step(16'hFFFF, 0, 0, 0, 0, 3'b111, "R4");
    step(16'hFFFF, 0, 0, 0, 0, 3'b111, "R4");
    // R6: clear keeps bits written 1
    step(16'hFFFF, 0, 0, 0, 1, 3'b101, "R6");
    step(16'hFFFF, 0, 0, 0, 1, 3'b000, "R6");
    // R6: set wins over clear in the same cycle
    step(16'h0000, 0, 0, 0, 0, 3'b111, "R6");
    step(16'h0040, 0, 0, 0, 1, 3'b000, "R6");
    step(16'h0040, 0, 0, 0, 1, 3'b000, "R6");
    // R2: select 3 is ignored; R3: single tap mapping
    cfg(2'd0, 8'h40); cfg(2'd1, 8'h00); cfg(2'd2, 8'h04);
    cfg(2'd3, 8'hFF);
    step(16'h0000, 0, 0, 0, 0, 3'b111, "R3");
    step(16'h0100, 0, 0, 0, 0, 3'b111, "R3");
    step(16'h1100, 0, 0, 0, 0, 3'b111, "R3");
    step(16'h0000, 0, 0, 0, 1, 3'b000, "R2");
    step(16'h3FC0, 0, 0, 0, 0, 3'b111, "R2");

    // Sweep all enable nibbles against a full counter run (R3 R4 R5 R10)
    for (int v = 0; v < 16; v++) begin
      logic [3:0] nv;
      nv = 4'(v);
      cfg(2'd0, {nv, ~nv});
      cfg(2'd1, {~nv, nv});
      cfg(2'd2, {nv, nv});
      for (int s = 0; s < 520; s++) begin
        logic [15:0] c;
        c = 16'(s * 32);
        if (s % 37 == 5)
          step(c, 0, 0, 0, 1, 3'(s), "R10");
        else
          step(c, 0, 0, 0, 0, 3'b111, "R4");
      end
    end

    done = 1'b1;
    summary();
  end

endmodule